// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block takes a DDR SDRAM device from power-on to a usable state, and then passes it to the main memory controller. It holds the clock enable low and issues nothing until a power-and-clock-good input is seen high. From then on it drives a fixed series of commands on the active-low command pins, along with the address and bank lines. The series loads the extended mode register so that the on-die DLL is enabled. It then resets the DLL and waits for it to lock, refreshes twice, and finally loads the operating mode with the configured CAS latency and burst length.

A single down-counter times every wait. Each wait is a number of NOP cycles set by a parameter. After the last mode-register load has had its settle time, the block raises a done flag. It keeps that flag high, with the bus idle, until the next reset. The main controller watches the flag to learn when it may take the command bus.

Top module: `ddr_init_seq`

## Requirements
- R1: While rst_n is low, and until pwr_ok has been sampled high at a rising clock edge, cke and init_done are low and the command pins show NOP. cke goes high in the cycle after that edge and stays high.
- R2: The first cycle with cke high carries a NOP. It is followed, in this order, by: precharge-all, extended mode load, mode load with DLL reset, precharge-all, refresh, refresh, and the final mode load. No other non-NOP command appears.
- R3: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as NOP 0111, PRECHARGE 0010, AUTO REFRESH 0001 and LOAD MODE 0000. Each command lasts exactly one cycle.
- R4: Every precharge drives addr bit 10 high, all other addr bits low, and ba = 00.
- R5: The extended mode load uses ba = 01 with addr all zero, so bit 0 = 0 (DLL enabled) and normal drive strength.
- R6: The DLL-reset mode load uses ba = 00. Its addr has bit 8 = 1, bits 6:4 = CAS code, bit 3 = 0 (sequential) and bits 2:0 = burst code, with every other bit 0. The CAS code is 010 for latency 2 and 011 for latency 3. The burst code is 001, 010 or 011 for burst length 2, 4 or 8.
- R7: The final mode load matches R6 except that addr bit 8 = 0.
- R8: Exactly DLL_LOCK NOP cycles separate the DLL-reset mode load from the next command.
- R9: The run of NOP cycles after a command has a fixed length: T_START after the first NOP, T_RP after each precharge, T_RFC after each refresh, and T_MRD after each mode load.
- R10: Exactly two refresh commands are issued.
- R11: init_done rises in the cycle right after the NOP gap that follows the final mode load. From then on it stays high, with cke high and NOP on the pins, until reset.
- R12: An asserted rst_n at any point, including in the middle of the sequence, at once drops cke and init_done and returns the pins to NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Power and clock are stable |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address / mode-register payload |
| ba | output | BA_W | Bank address / mode-register select |
| init_done | output | 1 | Initialization complete |

## Verification
The sequence is run from several power-good delays, including zero and a long hold-off. The same command order and the same relative timing, offset only by that delay, show that the start is keyed to the pwr_ok edge and not to the time since reset. In each run, every non-NOP command is logged with its cycle, code, bank and address. The bench compares each one against timestamps and mode words that it builds arithmetically from the parameters. This catches an off-by-one in any single gap, in particular the 200-cycle lock wait, as well as a swapped mode payload. A reset applied in the middle of the lock wait, followed by a clean rerun, separates a true restart from a sequencer that resumes where it stopped.

// File: rtl/ddr_init_pkg.sv
`timescale 1ns/1ps
package ddr_init_pkg;

  // Active-low {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [2:0] {
    GAP_START, GAP_RP, GAP_MRD, GAP_LOCK, GAP_RFC
  } gap_e;

  typedef enum logic [2:0] {
    PAY_ZERO, PAY_ALLBANK, PAY_EXT, PAY_MODE_RST, PAY_MODE_RUN
  } pay_e;

  typedef struct packed {
    cmd_e       cmd;
    logic [1:0] bank;
    pay_e       pay;
    gap_e       gap;
  } step_t;

  localparam int NUM_STEPS   = 8;
  localparam int ALLBANK_BIT = 10;
  localparam int DLL_RST_BIT = 8;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [2:0] burst_code(input int bl);
    case (bl)
      2:       return 3'd1;
      8:       return 3'd3;
      default: return 3'd2;
    endcase
  endfunction

  function automatic logic [2:0] cas_code(input int cl);
    return (cl == 3) ? 3'd3 : 3'd2;
  endfunction

  function automatic logic [15:0] mode_word(input int cl, input int bl, input logic dll_rst);
    logic [15:0] w;
    w = '0;
    w[2:0] = burst_code(bl);
    w[6:4] = cas_code(cl);
    w[DLL_RST_BIT] = dll_rst;
    return w;
  endfunction

  function automatic logic [15:0] ext_word(input logic dll_off, input logic weak_drive);
    logic [15:0] w;
    w = '0;
    w[0] = dll_off;
    w[1] = weak_drive;
    return w;
  endfunction

  function automatic logic [15:0] allbank_word();
    logic [15:0] w;
    w = '0;
    w[ALLBANK_BIT] = 1'b1;
    return w;
  endfunction

  // The ordered power-up program; the sequence itself is behaviour.
  function automatic step_t step_at(input int idx);
    case (idx)
      0:       return '{cmd: CMD_NOP, bank: 2'b00, pay: PAY_ZERO,     gap: GAP_START};
      1:       return '{cmd: CMD_PRE, bank: 2'b00, pay: PAY_ALLBANK,  gap: GAP_RP};
      2:       return '{cmd: CMD_LMR, bank: 2'b01, pay: PAY_EXT,      gap: GAP_MRD};
      3:       return '{cmd: CMD_LMR, bank: 2'b00, pay: PAY_MODE_RST, gap: GAP_LOCK};
      4:       return '{cmd: CMD_PRE, bank: 2'b00, pay: PAY_ALLBANK,  gap: GAP_RP};
      5:       return '{cmd: CMD_REF, bank: 2'b00, pay: PAY_ZERO,     gap: GAP_RFC};
      6:       return '{cmd: CMD_REF, bank: 2'b00, pay: PAY_ZERO,     gap: GAP_RFC};
      default: return '{cmd: CMD_LMR, bank: 2'b00, pay: PAY_MODE_RUN, gap: GAP_MRD};
    endcase
  endfunction

endpackage

// File: rtl/ddr_init_timer.sv
`timescale 1ns/1ps
module ddr_init_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expire
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  // Last cycle of a gap that was loaded with N: N cycles have elapsed.
  assign expire = (cnt_q == CW'(1));
endmodule

// File: rtl/ddr_init_step.sv
`timescale 1ns/1ps
module ddr_init_step
  import ddr_init_pkg::*;
#(
  parameter int SW       = 3,
  parameter int CW       = 8,
  parameter int T_START  = 2,
  parameter int T_RP     = 3,
  parameter int T_RFC    = 8,
  parameter int T_MRD    = 2,
  parameter int DLL_LOCK = 200
) (
  input  logic [SW-1:0] idx,
  output step_t         step_o,
  output logic [CW-1:0] gap_len,
  output logic          last
);
  always_comb begin
    step_o = step_at(int'(idx));
    case (step_o.gap)
      GAP_START: gap_len = CW'(T_START);
      GAP_RP:    gap_len = CW'(T_RP);
      GAP_MRD:   gap_len = CW'(T_MRD);
      GAP_LOCK:  gap_len = CW'(DLL_LOCK);
      GAP_RFC:   gap_len = CW'(T_RFC);
      default:   gap_len = '0;
    endcase
  end

  assign last = (idx == SW'(NUM_STEPS - 1));
endmodule

// File: rtl/ddr_init_enc.sv
`timescale 1ns/1ps
module ddr_init_enc
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int BA_W      = 2,
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 4
) (
  input  logic              issue,
  input  step_t             step_i,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba
);
  localparam logic [15:0] W_ALLBANK = allbank_word();
  localparam logic [15:0] W_EXT     = ext_word(1'b0, 1'b0);
  localparam logic [15:0] W_RST     = mode_word(CAS_LAT, BURST_LEN, 1'b1);
  localparam logic [15:0] W_RUN     = mode_word(CAS_LAT, BURST_LEN, 1'b0);

  logic [15:0] word;
  cmd_e        cmd;

  always_comb begin
    cmd  = CMD_NOP;
    word = '0;
    ba   = '0;
    if (issue) begin
      cmd = step_i.cmd;
      ba  = BA_W'(step_i.bank);
      case (step_i.pay)
        PAY_ALLBANK:  word = W_ALLBANK;
        PAY_EXT:      word = W_EXT;
        PAY_MODE_RST: word = W_RST;
        PAY_MODE_RUN: word = W_RUN;
        default:      word = '0;
      endcase
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign addr = ADDR_W'(word);
endmodule

// File: rtl/ddr_init_seq.sv
`timescale 1ns/1ps
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int T_START   = 2,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 8,
  parameter int T_MRD     = 2,
  parameter int DLL_LOCK  = 200,
  parameter int CAS_LAT   = 3,
  parameter int BURST_LEN = 4,
  parameter int ADDR_W    = 13,
  parameter int BA_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_ok,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              init_done
);
  localparam int MAX_GAP = max_of(max_of(max_of(T_START, T_RP), max_of(T_RFC, T_MRD)), DLL_LOCK);
  localparam int CW      = $clog2(MAX_GAP + 1);
  localparam int SW      = $clog2(NUM_STEPS);

  typedef enum logic [1:0] {ST_WAIT_PWR, ST_ISSUE, ST_GAP, ST_DONE} st_e;

  st_e           st_q, st_d;
  logic [SW-1:0] idx_q, idx_d;
  step_t         cur_step;
  logic [CW-1:0] gap_len;
  logic          step_last;
  logic          gap_expire;

  // Named internal events
  logic issue_evt;
  logic gap_zero;
  logic advance;

  assign issue_evt = (st_q == ST_ISSUE);
  assign gap_zero  = (gap_len == '0);
  assign advance   = (issue_evt && gap_zero) || (st_q == ST_GAP && gap_expire);

  ddr_init_step #(
    .SW(SW), .CW(CW), .T_START(T_START), .T_RP(T_RP),
    .T_RFC(T_RFC), .T_MRD(T_MRD), .DLL_LOCK(DLL_LOCK)
  ) u_step (
    .idx(idx_q), .step_o(cur_step), .gap_len(gap_len), .last(step_last)
  );

  ddr_init_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(issue_evt), .load_val(gap_len), .expire(gap_expire)
  );

  ddr_init_enc #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN)
  ) u_enc (
    .issue(issue_evt), .step_i(cur_step),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .ba(ba)
  );

  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    case (st_q)
      ST_WAIT_PWR: if (pwr_ok) begin
        st_d  = ST_ISSUE;
        idx_d = '0;
      end
      ST_ISSUE: if (!gap_zero) st_d = ST_GAP;
      default: ;
    endcase
    if (advance) begin
      if (step_last) st_d = ST_DONE;
      else begin
        st_d  = ST_ISSUE;
        idx_d = idx_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_WAIT_PWR;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  assign cke       = (st_q != ST_WAIT_PWR);
  assign init_done = (st_q == ST_DONE);
endmodule

// File: rtl/ddr_init_chk.sv
`timescale 1ns/1ps
module ddr_init_chk #(
  parameter int DLL_LOCK = 200
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cke,
  input logic [3:0] cmd,
  input logic       addr10,
  input logic       addr8,
  input logic [1:0] ba,
  input logic       init_done,
  input logic       issue_evt
);
  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] PRE = 4'b0010;
  localparam logic [3:0] REF = 4'b0001;
  localparam logic [3:0] LMR = 4'b0000;

  logic       lock_armed;
  int         lock_cnt;
  logic [2:0] ref_cnt;
  logic       dll_rst_cmd;

  assign dll_rst_cmd = (cmd == LMR) && (ba == 2'b00) && addr8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_armed <= 1'b0;
      lock_cnt   <= 0;
      ref_cnt    <= '0;
    end else begin
      if (dll_rst_cmd) begin
        lock_armed <= 1'b1;
        lock_cnt   <= 0;
      end else if (cmd != NOP) lock_armed <= 1'b0;
      else if (lock_armed)     lock_cnt <= lock_cnt + 1;
      if (cmd == REF && ref_cnt != 3'd7) ref_cnt <= ref_cnt + 1'b1;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (cmd == NOP) && !init_done);                                      // R1
  AST_CKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);                                                              // R1
  AST_CMD_FROM_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != NOP) |-> issue_evt);                                               // R3
  AST_ONE_CYCLE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != NOP) |=> (cmd == NOP));                                            // R9
  AST_PRE_ALLBANK: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == PRE) |-> addr10 && (ba == 2'b00));                                 // R4
  AST_LOCK_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_armed && cmd != NOP) |-> (lock_cnt == DLL_LOCK));                    // R8
  AST_REF_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cnt <= 3'd2);                                                          // R10
  AST_REF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (ref_cnt == 3'd2));                                          // R10
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);                                                  // R11
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (cmd == NOP) && cke);                                        // R11
endmodule

bind ddr_init_seq ddr_init_chk #(.DLL_LOCK(DLL_LOCK)) u_chk (
  .clk(clk), .rst_n(rst_n), .cke(cke),
  .cmd({cs_n, ras_n, cas_n, we_n}),
  .addr10(addr[10]), .addr8(addr[8]), .ba(ba[1:0]),
  .init_done(init_done), .issue_evt(issue_evt)
);

// File: tb/ddr_init_seq_test.sv
`timescale 1ns/1ps
module ddr_init_seq_test;
  localparam int T_START = 1, T_RP = 2, T_RFC = 4, T_MRD = 3, DLL_LOCK = 200;
  localparam int CL = 2, BL = 8, AW = 13, BW = 2;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, LMR = 4'b0000;

  logic clk = 1'b0, rst_n = 1'b0, pwr_ok = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [AW-1:0] addr;
  logic [BW-1:0] ba;
  int cyc = 0, checks = 0, errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  ddr_init_seq #(
    .T_START(T_START), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD), .DLL_LOCK(DLL_LOCK),
    .CAS_LAT(CL), .BURST_LEN(BL), .ADDR_W(AW), .BA_W(BW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba), .init_done(init_done)
  );

  wire [3:0] cmd = {cs_n, ras_n, cas_n, we_n};

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
  endtask

  function automatic int mode_exp(input bit dll_rst);
    int blc = 0;
    for (int v = BL; v > 1; v = v / 2) blc++;
    return (int'(dll_rst) * 256) + (CL * 16) + blc;
  endfunction

  task automatic run_seq(input int delay);
    int t_up, t_cke, t_done, n, refs, idle_bad, post_bad;
    bit first_nop;
    int ct[16];
    logic [3:0] cc[16];
    int ca[16];
    int cb[16];
    logic [3:0] e_cmd[7];
    int e_addr[7], e_ba[7], e_gap[7];
    int e_t;
    string e_req[7];

    rst_n = 1'b0; pwr_ok = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    idle_bad = 0;
    for (int i = 0; i < delay; i++) begin
      tick();
      if (cke || cmd != NOP || init_done) idle_bad++;
    end
    chk(idle_bad == 0, "R1", "quiet cycles before pwr_ok", idle_bad, 0);
    pwr_ok = 1'b1;
    t_up = cyc; t_cke = -1; t_done = -1; n = 0; refs = 0; post_bad = 0; first_nop = 1'b0;
    for (int i = 0; i < 400; i++) begin
      tick();
      if (t_cke < 0 && cke) begin
        t_cke = cyc;
        first_nop = (cmd == NOP);
      end
      if (t_done >= 0 && (!init_done || cmd != NOP || !cke)) post_bad++;
      if (cke && cmd != NOP) begin
        if (n < 16) begin
          ct[n] = cyc; cc[n] = cmd; ca[n] = int'(addr); cb[n] = int'(ba);
        end
        n++;
        if (cmd == REF) refs++;
      end
      if (init_done && t_done < 0) t_done = cyc;
      if (t_done >= 0 && cyc >= t_done + 6) break;
    end

    chk(t_cke == t_up + 1, "R1", "cke rise cycle", t_cke, t_up + 1);
    chk(first_nop, "R2", "first cke cycle is NOP", first_nop, 1);
    chk(n == 7, "R2", "non-NOP command count", n, 7);
    chk(refs == 2, "R10", "refresh count", refs, 2);

    e_cmd = '{PRE, LMR, LMR, PRE, REF, REF, LMR};
    e_ba  = '{0, 1, 0, 0, 0, 0, 0};
    e_addr = '{1024, 0, mode_exp(1'b1), 1024, 0, 0, mode_exp(1'b0)};
    e_gap = '{T_RP, T_MRD, DLL_LOCK, T_RP, T_RFC, T_RFC, T_MRD};
    e_req = '{"R4", "R5", "R6", "R4", "R3", "R3", "R7"};
    e_t = t_up + 1 + 1 + T_START;
    for (int k = 0; k < 7 && k < n; k++) begin
      chk(cc[k] == e_cmd[k], "R2", $sformatf("command %0d code", k), cc[k], e_cmd[k]);
      chk(ct[k] == e_t, (k == 3) ? "R8" : "R9", $sformatf("command %0d cycle", k), ct[k], e_t);
      chk(cb[k] == e_ba[k], e_req[k], $sformatf("command %0d bank", k), cb[k], e_ba[k]);
      chk(ca[k] == e_addr[k], e_req[k], $sformatf("command %0d addr", k), ca[k], e_addr[k]);
      e_t = e_t + 1 + e_gap[k];
    end
    chk(t_done == e_t, "R11", "init_done rise cycle", t_done, e_t);
    chk(post_bad == 0, "R11", "quiet bus after done", post_bad, 0);
  endtask

  task automatic mid_reset();
    rst_n = 1'b0; pwr_ok = 1'b0;
    tick(); tick();
    rst_n = 1'b1; pwr_ok = 1'b1;
    for (int i = 0; i < 40; i++) tick();  // inside the lock wait
    chk(cke == 1'b1, "R1", "cke high mid-sequence", cke, 1);
    rst_n = 1'b0;
    #1;
    chk(cke == 1'b0, "R12", "cke after async reset", cke, 0);
    chk(cmd == NOP, "R12", "command after async reset", cmd, NOP);
    chk(init_done == 1'b0, "R12", "done after async reset", init_done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick();
    chk(cke == 1'b0 && init_done == 1'b0, "R1", "reset state cke/done", {cke, init_done}, 0);
    chk(cmd == NOP, "R3", "reset state command", cmd, NOP);
    run_seq(3);
    mid_reset();
    run_seq(0);
    run_seq(9);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule